// File: doc/BRIEF.md
# Serial "b-a-a" Sequence Recognizer

This block watches a one-bit serial stream of two symbols, `a` and `b`, and flags every position where the three most recently accepted symbols are `b`, `a`, `a`, in that order. Symbols arrive on a valid/ready transfer interface. The block never pushes back: `in_ready` is held high, and every cycle with `in_valid` high moves one symbol into the recognizer. Cycles with `in_valid` low carry no symbol. They leave the recognizer untouched, whatever `in_sym` holds.

The state is held in two JK flip-flop cells. Explicit J and K excitation terms drive these cells; the next state is never assigned directly. A parameter picks one of two variants. The Mealy variant has three states. It flags the match in the same cycle as the symbol that completes it, using the current input together with the state. The Moore variant has four states. Its flag comes from a registered state and appears in the cycle after the completing transfer. In both variants a match may overlap the previous one: after a detection, a new `b` starts the next candidate at once.

Top module: `trio_seq_detector`

## Requirements
- R1: Symbol `a` is encoded as `in_sym = 0` and symbol `b` as `in_sym = 1`. In the Mealy variant, `det` is 1 in a transfer cycle exactly when that symbol and the two accepted before it read `b`, `a`, `a` (oldest first). In that variant `det_valid` equals `in_valid` in the same cycle.
- R2: In the Moore variant, `det_valid` is 1 in the cycle after each accepted transfer and 0 otherwise. `det` is 1 in that cycle exactly when the transfer completed `b`, `a`, `a`.
- R3: Matches overlap. A `b` accepted right after a detection begins a new match, so `b a a b a a` flags twice.
- R4: A cycle with `in_valid` low changes no state, whatever `in_sym` holds. In it the Mealy `det` is 0. In the cycle after it, the Moore `det_valid` and `det` are 0.
- R5: Synchronous reset `rst` returns the recognizer to its idle state. It discards partial matches, and `det` and `det_valid` are 0 in the cycle that follows it.
- R6: `in_ready` is always 1. The block applies no back-pressure.
- R7: Each state cell behaves as a JK flip-flop: J=0,K=0 holds, J=0,K=1 clears, J=1,K=0 sets, and J=1,K=1 toggles.
- R8: The Mealy variant uses codes 00, 01 and 10 on (Q1,Q0). Its excitation is J0=x, K0=not x, J1=(not x)·Q0 and K1=1, qualified by the transfer. If the unused code 11 is ever held, the next state is 00 and `det` stays 0.
- R9: In the Moore variant, `det` rises only when state code 11 has been reached through an accepted `a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A symbol is offered this cycle |
| in_ready | output | 1 | Block accepts a symbol (constant 1) |
| in_sym | input | 1 | Offered symbol: 0 = a, 1 = b |
| det_valid | output | 1 | Qualifies `det` |
| det | output | 1 | Pattern b,a,a just completed |

## Verification
Several properties are checked on every cycle: the hold, clear, set and toggle rules of each JK cell; the bar on the Mealy unused code; the rule that a cycle with no transfer leaves the state stable and the flag low; and the rule that a Moore flag always follows an accepted `a`. Whether the flag marks exactly the positions where `b a a` ends is a property of whole input histories. Only the bench's scenarios can show that. They include overlapping matches, runs of `b`, idle gaps carrying stray symbols, and a reset in the middle of a match, and a random stream is compared against a three-symbol history model for both variants.

// File: rtl/trio_pkg.sv
package trio_pkg;

  typedef enum logic {
    VAR_MEALY = 1'b0,
    VAR_MOORE = 1'b1
  } variant_e;

  localparam int STATE_W = 2;
  localparam logic SYM_A = 1'b0;
  localparam logic SYM_B = 1'b1;

  typedef logic [STATE_W-1:0] code_t;

  localparam code_t ST_IDLE = 2'b00;  // nothing useful seen
  localparam code_t ST_GOTB = 2'b01;  // last symbol b
  localparam code_t ST_GOTBA = 2'b10; // last two b,a
  localparam code_t ST_FULL = 2'b11;  // Moore only: b,a,a complete

endpackage

// File: rtl/jk_cell.sv
module jk_cell (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      unique case ({j, k})
        2'b00: q <= q;
        2'b01: q <= 1'b0;
        2'b10: q <= 1'b1;
        2'b11: q <= ~q;
      endcase
    end
  end

  p_jk_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!j && !k) |=> (q == $past(q)));
  p_jk_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (!j && k) |=> !q);
  p_jk_set_r7: assert property (@(posedge clk) disable iff (rst)
    (j && !k) |=> q);
  p_jk_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    (j && k) |=> (q != $past(q)));

endmodule

// File: rtl/trio_mealy_core.sv
module trio_mealy_core
  import trio_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic sym,
  output logic det_valid,
  output logic det
);

  code_t q;
  code_t j;
  code_t k;
  logic  stray;

  // code 11 is never produced by the excitation below; recover if held
  assign stray = q[1] & q[0];

  always_comb begin
    j[0] = take & sym & ~stray;
    k[0] = (take & ~sym) | stray;
    j[1] = take & ~sym & q[0] & ~stray;
    k[1] = take | stray;
  end

  for (genvar gi = 0; gi < STATE_W; gi++) begin : g_cell
    jk_cell u_cell (
      .clk (clk),
      .rst (rst),
      .j   (j[gi]),
      .k   (k[gi]),
      .q   (q[gi])
    );
  end

  assign det_valid = take;
  assign det       = take & (sym == SYM_A) & q[1] & ~q[0];

  p_no_stray_code_r8: assert property (@(posedge clk) disable iff (rst)
    q != ST_FULL);
  p_idle_holds_r4: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(q));
  p_idle_no_flag_r4: assert property (@(posedge clk) disable iff (rst)
    !take |-> !det);
  p_flag_on_a_r1: assert property (@(posedge clk) disable iff (rst)
    det |-> (sym == SYM_A));
  p_flag_returns_idle_r3: assert property (@(posedge clk) disable iff (rst)
    det |=> (q == ST_IDLE));

endmodule

// File: rtl/trio_moore_core.sv
module trio_moore_core
  import trio_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic sym,
  output logic det_valid,
  output logic det
);

  code_t q;
  code_t j;
  code_t k;
  logic  took_q;

  // derived from: IDLE -a-> IDLE, GOTB -a-> GOTBA, GOTBA -a-> FULL,
  // FULL -a-> IDLE, any -b-> GOTB
  always_comb begin
    j[0] = take & (sym | q[1]);
    k[0] = take & ~sym;
    j[1] = take & ~sym & q[0];
    k[1] = take & (sym | q[0]);
  end

  for (genvar gi = 0; gi < STATE_W; gi++) begin : g_cell
    jk_cell u_cell (
      .clk (clk),
      .rst (rst),
      .j   (j[gi]),
      .k   (k[gi]),
      .q   (q[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) took_q <= 1'b0;
    else     took_q <= take;
  end

  assign det_valid = took_q;
  assign det       = took_q & (q == ST_FULL);

  p_moore_valid_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> det_valid);
  p_moore_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !take |=> (!det_valid && !det && $stable(q)));
  p_moore_flag_src_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(det) |-> ($past(take) && ($past(sym) == SYM_A) && ($past(q) == ST_GOTBA)));

endmodule

// File: rtl/trio_seq_detector.sv
module trio_seq_detector
  import trio_pkg::*;
#(
  parameter variant_e VARIANT = VAR_MEALY
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_sym,
  output logic det_valid,
  output logic det
);

  logic take;

  assign in_ready = 1'b1;
  assign take     = in_valid & in_ready;

  if (VARIANT == VAR_MEALY) begin : g_mealy
    trio_mealy_core u_core (
      .clk       (clk),
      .rst       (rst),
      .take      (take),
      .sym       (in_sym),
      .det_valid (det_valid),
      .det       (det)
    );
  end else begin : g_moore
    trio_moore_core u_core (
      .clk       (clk),
      .rst       (rst),
      .take      (take),
      .sym       (in_sym),
      .det_valid (det_valid),
      .det       (det)
    );
  end

  p_reset_quiet_r5: assert property (@(posedge clk)
    rst |=> (!det && (VARIANT == VAR_MEALY || !det_valid)));

endmodule

// File: tb/tb_trio_seq_detector.sv
`timescale 1ns/1ps
module tb_trio_seq_detector;
  import trio_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_sym = 1'b0;
  logic rdy_a, dv_a, det_a;
  logic rdy_b, dv_b, det_b;

  int checks = 0;
  int errors = 0;
  logic [1:0] hist = 2'b00; // [1] older, [0] newer accepted symbol

  always #2 clk = ~clk;

  trio_seq_detector #(.VARIANT(VAR_MEALY)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_a),
    .in_sym(in_sym), .det_valid(dv_a), .det(det_a));

  trio_seq_detector #(.VARIANT(VAR_MOORE)) dut_moore (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_b),
    .in_sym(in_sym), .det_valid(dv_b), .det(det_b));

  // {valid, sym, expected flag}
  localparam logic [2:0] VEC [17] = '{
    3'b110, 3'b100, 3'b101, 3'b110, 3'b100, 3'b101, 3'b110, 3'b110,
    3'b100, 3'b000, 3'b101, 3'b100, 3'b110, 3'b100, 3'b110, 3'b100,
    3'b101
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step(input logic v, input logic s, input logic e);
    @(negedge clk);
    in_valid = v;
    in_sym   = s;
    #1;
    check(det_a == e, "R1 mealy det", det_a, e);
    check(dv_a == v, "R1 mealy det_valid", dv_a, v);
    check(rdy_a && rdy_b, "R6 in_ready", rdy_a, 1);
    if (v) hist = {hist[0], s};
    @(posedge clk);
    #1;
    check(dv_b == v, "R2 moore det_valid", dv_b, v);
    check(det_b == (v & e), "R2 moore det", det_b, v & e);
  endtask

  function automatic logic ref_flag(input logic v, input logic s);
    return v && (s == SYM_A) && (hist[0] == SYM_A) && (hist[1] == SYM_B);
  endfunction

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R5: idle after reset
    check(det_a == 0 && det_b == 0 && dv_b == 0, "R5 reset outputs", det_a | det_b | dv_b, 0);

    // table walk: R1, R2, R3 overlap, R4 gap with stray symbol
    foreach (VEC[i]) step(VEC[i][2], VEC[i][1], VEC[i][0]);

    // R3: b right after detection
    step(1, 1, 0); step(1, 0, 0); step(1, 0, 1);
    step(1, 1, 0); step(1, 0, 0); step(1, 0, 1);

    // R4: idle cycles with b on the wire do not disturb b,a -> a
    step(1, 1, 0); step(1, 0, 0);
    step(0, 1, 0); step(0, 1, 0); step(0, 0, 0);
    step(1, 0, 1);

    // R5: reset mid-match discards b,a
    step(1, 1, 0); step(1, 0, 0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_sym = 1'b0;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    hist = 2'b00;
    #1;
    check(det_b == 0 && dv_b == 0, "R5 moore after reset", det_b | dv_b, 0);
    step(1, 0, 0);
    check(det_a == 0, "R5 no match after reset", det_a, 0);

    // random stream against history model (R1, R2, R3, R4)
    for (int n = 0; n < 3000; n++) begin
      logic v, s;
      v = ($urandom_range(3) != 0);
      s = $urandom_range(1);
      step(v, s, ref_flag(v, s));
    end

    finish_run();
  end

endmodule